// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial Word Loader

This block is the digital front end of a two-channel 12-bit converter. A host streams bits, most significant first, on a data pin that is sampled on each rising edge of a serial clock. A separate active-low select gates the serial clock. The received word sits in a shift register until one of two active-low, level-sensitive load strobes copies it into that channel's holding register. A strobe held low keeps its channel transparent, so the channel follows every new bit. Both strobes low together write the same word to both channels.

The holding registers have an asynchronous active-low preset. It forces both channels to zero or to midscale (0x800), selected by a level pin. It outranks the load strobes and leaves the shift register alone. A shutdown input comes out again as a status flag and touches no register. All serial-side inputs are sampled by a fast system clock through synchronizer chains. Serial clock edges are found on the synchronized copy.

Top module: `dac_loader`

## Requirements
- R1: With the select low, each rising edge of the serial clock shifts the register left by one and places the data bit in bit 0, so the first bit sent ends up as the most significant.
- R2: With the select high, serial clock edges leave the shift register unchanged.
- R3: A frame longer than the word keeps only the last WORD_W bits received. A 16-bit frame 0xF5A3 loads 0x5A3.
- R4: While the channel A strobe is low and the preset is idle, channel A takes the current shift register value on every system clock, including the value just shifted in. After the strobe rises it holds its value.
- R5: The channel B strobe acts the same way on channel B, independently of channel A. Both strobes low together give both channels the same word.
- R6: The load strobes work at either level of the select.
- R7: While the preset is low, both channels read 0x800 when the preset-select pin is high and 0x000 when it is low. This takes effect without waiting for a clock edge and overrides the strobes. After the preset is released the preset value holds for SYNC_STAGES further system clock edges.
- R8: The preset does not change the shift register. A load after the preset returns the word that was shifted in before it.
- R9: The shutdown flag is high while the shutdown input is low, after SYNC_STAGES system clocks. Shutdown changes no register, and shifting and loading keep working under it.
- R10: Power-on reset clears the shift register and puts both channels at the preset-select code.
- R11: Inputs reach the logic after SYNC_STAGES system clock edges. A shift or load acts on the following edge, and the new value is visible after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ser_clk | input | 1 | Serial bit clock; sampling on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_sel_n | input | 1 | Active-low select that enables shifting |
| load_a_n | input | 1 | Active-low level-sensitive load for channel A |
| load_b_n | input | 1 | Active-low level-sensitive load for channel B |
| preset_n | input | 1 | Active-low asynchronous channel preset |
| preset_mid | input | 1 | Preset value select: 1 gives midscale, 0 gives zero |
| pwrdn_n | input | 1 | Active-low shutdown request |
| chan_a | output | WORD_W | Channel A holding register |
| chan_b | output | WORD_W | Channel B holding register |
| pwrdn_flag | output | 1 | High while shutdown is requested |

## Verification
The bench builds the block with its default parameters, WORD_W of 12 and SYNC_STAGES of 2. With those values a 16-bit frame overflows the word by four bits, which exercises the discard of the earliest bits. A two-stage chain also makes each latency short enough to count edge by edge. A reference model with a sample history compares both channels and the shutdown flag on every clock. This covers transparent tracking while a strobe stays low, the preset value under both select levels, and the preset-release hold window.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

  // Serial-side inputs carried together through one synchronizer chain.
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic sel_n;
    logic lda_n;
    logic ldb_n;
    logic pwrdn_n;
  } ctl_t;

  // Idle levels: serial clock low, every active-low input released.
  localparam ctl_t CTL_IDLE = '{sclk: 1'b0, sdata: 1'b0, sel_n: 1'b1,
                                lda_n: 1'b1, ldb_n: 1'b1, pwrdn_n: 1'b1};

endpackage

// File: rtl/dac_loader_sync.sv
module dac_loader_sync #(
  parameter int unsigned     N       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dac_loader_shifter.sv
module dac_loader_shifter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdata_s,
  input  logic         sel_n_s,
  output logic         shift_evt,
  output logic [W-1:0] shift_nxt,
  output logic [W-1:0] shift_q
);

  logic sclk_d;

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] cur, input logic b);
    push_bit = {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign shift_evt = sclk_s & ~sclk_d & ~sel_n_s;
  assign shift_nxt = shift_evt ? push_bit(shift_q, sdata_s) : shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_nxt;
  end

endmodule

// File: rtl/dac_loader_chan.sv
module dac_loader_chan #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         ch_rst_n,
  input  logic [W-1:0] preset_val,
  input  logic         load_act,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge ch_rst_n) begin
    if (!ch_rst_n)     q <= preset_val;
    else if (load_act) q <= din;
  end

endmodule

// File: rtl/dac_loader.sv
module dac_loader #(
  parameter int unsigned WORD_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_sel_n,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              preset_n,
  input  logic              preset_mid,
  input  logic              pwrdn_n,
  output logic [WORD_W-1:0] chan_a,
  output logic [WORD_W-1:0] chan_b,
  output logic              pwrdn_flag
);
  import dac_loader_pkg::*;

  localparam int unsigned CTL_W  = $bits(ctl_t);
  localparam int unsigned N_CHAN = 2;

  function automatic logic [WORD_W-1:0] preset_code(input logic mid);
    preset_code = '0;
    preset_code[WORD_W-1] = mid;
  endfunction

  ctl_t                          ctl_raw, ctl_s;
  logic                          chan_arst_n, ch_rst_n;
  logic [WORD_W-1:0]             preset_val, shift_q, shift_nxt;
  logic                          shift_evt, sel_idle, lda_act, ldb_act;
  logic [N_CHAN-1:0]             load_act;
  logic [N_CHAN-1:0][WORD_W-1:0] chan_q;

  assign ctl_raw = '{sclk: ser_clk, sdata: ser_data, sel_n: ser_sel_n,
                     lda_n: load_a_n, ldb_n: load_b_n, pwrdn_n: pwrdn_n};

  dac_loader_sync #(.N(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  // Channel reset: asserted at once, released on the system clock.
  assign chan_arst_n = rst_n & preset_n;

  dac_loader_sync #(.N(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (chan_arst_n),
    .d     (1'b1),
    .q     (ch_rst_n)
  );

  assign preset_val = preset_code(preset_mid);

  dac_loader_shifter #(.W(WORD_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (ctl_s.sclk),
    .sdata_s   (ctl_s.sdata),
    .sel_n_s   (ctl_s.sel_n),
    .shift_evt (shift_evt),
    .shift_nxt (shift_nxt),
    .shift_q   (shift_q)
  );

  assign load_act = {~ctl_s.ldb_n, ~ctl_s.lda_n};
  assign lda_act  = load_act[0];
  assign ldb_act  = load_act[1];
  assign sel_idle = ctl_s.sel_n;

  for (genvar gi = 0; gi < N_CHAN; gi++) begin : g_chan
    dac_loader_chan #(.W(WORD_W)) u_chan (
      .clk        (clk),
      .ch_rst_n   (ch_rst_n),
      .preset_val (preset_val),
      .load_act   (load_act[gi]),
      .din        (shift_nxt),
      .q          (chan_q[gi])
    );
  end

  assign chan_a     = chan_q[0];
  assign chan_b     = chan_q[1];
  assign pwrdn_flag = ~ctl_s.pwrdn_n;

endmodule

// File: rtl/dac_loader_checker.sv
module dac_loader_checker #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         preset_n,
  input logic         preset_mid,
  input logic         pwrdn_n,
  input logic         pwrdn_flag,
  input logic [W-1:0] chan_a,
  input logic [W-1:0] chan_b,
  input logic [W-1:0] shift_q,
  input logic         shift_evt,
  input logic         sel_idle,
  input logic         lda_act,
  input logic         ldb_act,
  input logic         ch_rst_n
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  int unsigned cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc <= 0;
    else if (cyc < STAGES)    cyc <= cyc + 1;
  end

  p_shift_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shift_q[W-1:1] == $past(shift_q[W-2:0]));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_idle |=> $stable(shift_q));

  p_track_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rst_n && lda_act) |=> (!ch_rst_n || chan_a == shift_q));

  p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rst_n && !lda_act) |=> (!ch_rst_n || $stable(chan_a)));

  p_track_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rst_n && ldb_act) |=> (!ch_rst_n || chan_b == shift_q));

  p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rst_n && !ldb_act) |=> (!ch_rst_n || $stable(chan_b)));

  p_preset_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> (chan_a == ($past(preset_mid) ? MID : '0)) &&
                  (chan_b == ($past(preset_mid) ? MID : '0)));

  p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= STAGES) |-> pwrdn_flag == !$past(pwrdn_n, 2));

endmodule

bind dac_loader dac_loader_checker #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset_n   (preset_n),
  .preset_mid (preset_mid),
  .pwrdn_n    (pwrdn_n),
  .pwrdn_flag (pwrdn_flag),
  .chan_a     (chan_a),
  .chan_b     (chan_b),
  .shift_q    (shift_q),
  .shift_evt  (shift_evt),
  .sel_idle   (sel_idle),
  .lda_act    (lda_act),
  .ldb_act    (ldb_act),
  .ch_rst_n   (ch_rst_n)
);

// File: tb/dac_loader_bench.sv
module dac_loader_bench;

  localparam int W = 12;
  localparam int L = 2;

  typedef struct packed {
    logic sclk, sdata, sel_n, lda_n, ldb_n, pwrdn_n;
  } smp_t;
  localparam smp_t IDLE = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_data, ser_sel_n, load_a_n, load_b_n;
  logic preset_n, preset_mid, pwrdn_n;
  logic [W-1:0] chan_a, chan_b;
  logic pwrdn_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  smp_t         hist[$];
  logic [W-1:0] m_sh, m_a, m_b;
  logic         m_flag;
  int           m_rc;

  always #4 clk = ~clk;

  dac_loader u_dac_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_sel_n(ser_sel_n), .load_a_n(load_a_n), .load_b_n(load_b_n),
    .preset_n(preset_n), .preset_mid(preset_mid), .pwrdn_n(pwrdn_n),
    .chan_a(chan_a), .chan_b(chan_b), .pwrdn_flag(pwrdn_flag)
  );

  function automatic logic [W-1:0] code_of(input logic mid);
    return mid ? W'(2 ** (W - 1)) : '0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: inputs reach the logic L edges late.
  always @(posedge clk) begin
    smp_t cur, s2, s3;
    cur = '{ser_clk, ser_data, ser_sel_n, load_a_n, load_b_n, pwrdn_n};
    if (!rst_n) begin
      m_sh = '0; m_a = code_of(preset_mid); m_b = m_a; m_rc = 0; m_flag = 1'b0;
      hist.delete();
      for (int i = 0; i < L + 2; i++) hist.push_front(IDLE);
    end else begin
      hist.push_front(cur);
      s2 = hist[L];
      s3 = hist[L+1];
      if (s2.sclk && !s3.sclk && !s2.sel_n) m_sh = {m_sh[W-2:0], s2.sdata};
      if (!preset_n) begin
        m_a = code_of(preset_mid); m_b = m_a; m_rc = 0;
      end else if (m_rc < L) begin
        m_a = code_of(preset_mid); m_b = m_a; m_rc++;
      end else begin
        if (!s2.lda_n) m_a = m_sh;
        if (!s2.ldb_n) m_b = m_sh;
      end
      m_flag = !hist[L-1].pwrdn_n;
      while (hist.size() > L + 2) void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done && hist.size() != 0) begin
      check("R4 model chan_a", chan_a, m_a);
      check("R5 model chan_b", chan_b, m_b);
      check("R9 model flag", W'(pwrdn_flag), W'(m_flag));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; ser_clk = 1'b0; tick(2);
    ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] v, input int nbits);
    ser_sel_n = 1'b0; tick(1);
    for (int i = nbits - 1; i >= 0; i--) send_bit(v[i]);
    tick(3);
    ser_sel_n = 1'b1; tick(3);
  endtask

  task automatic pulse_load(input bit a, input bit b);
    if (a) load_a_n = 1'b0;
    if (b) load_b_n = 1'b0;
    tick(3);
    load_a_n = 1'b1; load_b_n = 1'b1;
    tick(4);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; ser_clk = 0; ser_data = 0; ser_sel_n = 1; load_a_n = 1; load_b_n = 1;
    preset_n = 1; preset_mid = 1; pwrdn_n = 1;
    tick(3);
    check("R10 power-on chan_a midscale", chan_a, 12'h800);
    check("R10 power-on chan_b midscale", chan_b, 12'h800);
    rst_n = 1; tick(4);

    // R3 and R1: 16-bit frame, only the last 12 bits kept.
    send_frame(16'hF5A3, 16);
    pulse_load(1, 0);
    check("R3 frame overflow chan_a", chan_a, 12'h5A3);
    check("R5 chan_b untouched by strobe A", chan_b, 12'h800);

    // R2: serial clock pulses with select high do not shift.
    ser_sel_n = 1'b1;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    tick(3);
    pulse_load(0, 1);
    check("R2 select high holds shift, R6 load with select high", chan_b, 12'h5A3);

    // R5: both strobes together.
    send_frame(16'h0123, 16);
    pulse_load(1, 1);
    check("R5 joint load chan_a", chan_a, 12'h123);
    check("R5 joint load chan_b", chan_b, 12'h123);

    // R4 and R6: transparent tracking with strobe held while select is low.
    load_a_n = 1'b0; tick(4);
    ser_sel_n = 1'b0; tick(1);
    send_bit(1'b1); tick(3); check("R4 track bit1", chan_a, 12'h247);
    send_bit(1'b0); tick(3); check("R4 track bit2", chan_a, 12'h48E);
    send_bit(1'b1); tick(3); check("R4 track bit3", chan_a, 12'h91D);
    send_bit(1'b1); tick(3); check("R4 track bit4", chan_a, 12'h23B);
    load_a_n = 1'b1; tick(4);
    send_bit(1'b0); tick(4);
    check("R4 latched after release", chan_a, 12'h23B);
    check("R5 chan_b not following", chan_b, 12'h123);
    ser_sel_n = 1'b1; tick(2);

    // R9: shutdown leaves shifting and loading alive.
    pwrdn_n = 1'b0; tick(3);
    check("R9 flag raised", W'(pwrdn_flag), W'(1));
    send_frame(16'h0ABC, 12);
    pulse_load(0, 1);
    check("R9 load during shutdown", chan_b, 12'hABC);
    pwrdn_n = 1'b1; tick(3);
    check("R9 flag cleared", W'(pwrdn_flag), W'(0));
    check("R9 chan_b kept", chan_b, 12'hABC);
    check("R9 chan_a kept", chan_a, 12'h23B);

    // R7: preset to zero then midscale, overriding a held strobe.
    preset_mid = 1'b0; load_a_n = 1'b0; preset_n = 1'b0;
    #1;
    check("R7 async preset zero chan_a", chan_a, 12'h000);
    check("R7 async preset zero chan_b", chan_b, 12'h000);
    tick(1);
    preset_mid = 1'b1; tick(2);
    check("R7 preset midscale chan_a", chan_a, 12'h800);
    check("R7 preset midscale chan_b", chan_b, 12'h800);
    preset_n = 1'b1; tick(1);
    check("R7 hold after release", chan_a, 12'h800);
    tick(4);
    check("R8 shift kept through preset", chan_a, 12'hABC);
    check("R7 chan_b stays preset", chan_b, 12'h800);
    load_a_n = 1'b1; tick(3);

    // R10: power-on reset with zero select clears the shift register.
    preset_mid = 1'b0; rst_n = 1'b0; tick(2);
    check("R10 reset zero chan_a", chan_a, 12'h000);
    check("R10 reset zero chan_b", chan_b, 12'h000);
    rst_n = 1'b1; tick(4);
    preset_mid = 1'b1; tick(1);
    pulse_load(1, 0);
    check("R10 shift cleared by reset", chan_a, 12'h000);
    check("R11 untouched chan_b", chan_b, 12'h000);

    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule